// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from up to sixteen hardware sources into a sticky status register. Software clears status bits by writing ones, and a mask register decides which pending bits may request service. The request leaves the block as an active-low, open-drain style line. It is modelled as a pull-low enable together with the level that the external pull-up would produce.

The output follows one extra rule. Several unmasked sources may be pending when software acknowledges only some of them. If at least one unmasked source is still pending after that write, the line is released for exactly one clock and then pulled low again. An edge-sensitive host therefore sees a new falling edge, and a level-sensitive host sees a clean re-request. When software acknowledges every pending unmasked source, the line is simply released.

Top module: `irq_status_ctrl`

## Requirements
- R1: A status bit whose mask bit is 0 pulls the line low (`irq_drive_low_o`=1, `irq_n_o`=0) from the clock edge that captures it. A status bit whose mask bit is 1 never pulls the line low.
- R2: A write with `wr_sel_i`=0 (status select) clears every status bit where `wr_data_i` holds a 1, at the next clock edge.
- R3: Status bits written with 0 keep their value, and a write with `wr_sel_i`=1 leaves the status register unchanged.
- R4: When an event pulse on `evt_i[i]` and a write-1 clear of bit i arrive in the same clock, the bit is set afterwards.
- R5: A partial acknowledge releases the line for one clock and then pulls it low again. A partial acknowledge is a status write where two or more unmasked bits were pending, at least one of them is cleared (and not re-set by its event in that clock), and at least one unmasked bit is pending after the write.
- R6: A write that leaves no unmasked status bit pending releases the line at the next edge, with no gap-and-reassert behaviour.
- R7: A write with `wr_sel_i`=1 loads the whole mask from `wr_data_i`. Clearing the mask bit of an already pending status bit pulls the line low at that edge.
- R8: `rd_data_o` shows the status register when `rd_sel_i`=0 and the mask register when `rd_sel_i`=1. It is combinational and reading has no side effect on either register.
- R9: Reset sets status to 0, sets all mask bits to 1 and releases the line.
- R10: `irq_n_o` is 0 exactly when `irq_drive_low_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | One-clock event pulses, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (write-1-clear), 1 mask |
| wr_data_i | input | NUM_SRC | Write data |
| rd_sel_i | input | 1 | Read target: 0 status, 1 mask |
| rd_data_o | output | NUM_SRC | Read data |
| irq_drive_low_o | output | 1 | 1 while the block pulls the interrupt line low |
| irq_n_o | output | 1 | Resulting line level (0 = request) |

## Verification
The hardest case to reach is the one-clock gap. Two or more unmasked sources must be pending at once, and a single status write must then clear some of them but not all. The stimulus first unmasks a group of sources and fires several event pulses. It then writes a partial acknowledge and samples the line in the clock of the write and in the clock after it. Variants are built the same way: a clear that hits only a masked bit, and a clear racing an event on the same bit. Both must not produce the gap.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] status_d_o,
    output logic [NUM_SRC-1:0] status_q_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } status_t;

    status_t            st_d, st_q;
    logic [NUM_SRC-1:0] bit_d;

    // per-bit next value: event set has priority over clear
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        assign bit_d[i] = evt_i[i] | (st_q.bits[i] & ~clr_i[i]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = bit_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_d_o = st_d.bits;
    assign status_q_o = st_q.bits;

    // R2: cleared bits without a racing event read 0 afterwards
    a_r2_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((status_q_o & $past(clr_i & ~evt_i)) == '0));

    // R3: bits not cleared never fall
    a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q_o & ~clr_i) & ~status_q_o) == '0));

    // R4: an event always leaves its bit set
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_q_o & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [NUM_SRC-1:0] data_i,
    output logic [NUM_SRC-1:0] mask_d_o,
    output logic [NUM_SRC-1:0] mask_q_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (load_i) mk_d.bits = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '{bits: '1};
        else        mk_q <= mk_d;
    end

    assign mask_d_o = mk_d.bits;
    assign mask_q_o = mk_q.bits;

    // R7: a mask write loads the full word
    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (mask_q_o == $past(data_i)));

    // R3: without a write the mask holds
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(mask_q_o));

endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] act_q_i,
    input  logic [NUM_SRC-1:0] act_d_i,
    input  logic [NUM_SRC-1:0] acked_i,
    output logic               irq_q_o
);

    typedef struct packed {
        logic req;
    } line_t;

    line_t line_d, line_q;
    logic  multi_pending;
    logic  partial_ack;

    // two or more bits set: removing the lowest set bit leaves something
    assign multi_pending = |(act_q_i & (act_q_i - 1'b1));
    assign partial_ack   = multi_pending && (|acked_i) && (|act_d_i);

    always_comb begin
        line_d     = line_q;
        line_d.req = (|act_d_i) && !partial_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign irq_q_o = line_q.req;

    // R1: a request is only held while some unmasked bit is pending
    a_r1_req_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q_o |-> (|act_q_i));

    // R5: a partial acknowledge opens a gap at the next edge
    a_r5_gap_opens: assert property (@(posedge clk) disable iff (!rst_n)
        partial_ack |=> !irq_q_o);

    // R6: nothing pending after the edge means the line is released
    a_r6_full_release: assert property (@(posedge clk) disable iff (!rst_n)
        !(|act_d_i) |=> !irq_q_o);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic               wr_sel_i,
    input  logic [NUM_SRC-1:0] wr_data_i,
    input  logic               rd_sel_i,
    output logic [NUM_SRC-1:0] rd_data_o,
    output logic               irq_drive_low_o,
    output logic               irq_n_o
);

    import irq_pkg::*;

    logic [NUM_SRC-1:0] clr;
    logic               mask_load;
    logic [NUM_SRC-1:0] status_d, status_q;
    logic [NUM_SRC-1:0] mask_d, mask_q;
    logic [NUM_SRC-1:0] act_d, act_q, acked;
    logic               irq_q;

    assign clr       = (wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STATUS)) ? wr_data_i : '0;
    assign mask_load = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_MASK);

    irq_status_reg #(.NUM_SRC(NUM_SRC)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .clr_i      (clr),
        .status_d_o (status_d),
        .status_q_o (status_q)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (mask_load),
        .data_i   (wr_data_i),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q)
    );

    assign act_q = status_q & ~mask_q;
    assign act_d = status_d & ~mask_d;
    assign acked = act_q & clr & ~evt_i;

    irq_line_ctrl #(.NUM_SRC(NUM_SRC)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_q_i (act_q),
        .act_d_i (act_d),
        .acked_i (acked),
        .irq_q_o (irq_q)
    );

    assign rd_data_o       = (reg_sel_e'(rd_sel_i) == SEL_MASK) ? mask_q : status_q;
    assign irq_drive_low_o = irq_q;
    assign irq_n_o         = irq_q ? 1'b0 : 1'b1;

    // R10: line level and pull-low enable stay complementary
    a_r10_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_o != irq_drive_low_o);

    // R1: a pending unmasked bit with no write in progress keeps the line low
    a_r1_pending_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ((|act_q) && !wr_en_i && $past(!wr_en_i)) |-> irq_drive_low_o);

endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;

    localparam int W = 16;

    typedef struct {
        logic         irq_n;
        logic [W-1:0] rd;
        logic         rsel;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt = '0;
    logic         we = 1'b0;
    logic         wsel = 1'b0;
    logic [W-1:0] wdata = '0;
    logic         rsel = 1'b0;
    logic [W-1:0] rd_data;
    logic         drive_low, irq_n;

    int unsigned n_chk = 0;
    int unsigned n_err = 0;
    bit          done = 1'b0;
    exp_t        sb[$];

    logic [W-1:0] m_st, m_mk;

    always #2.5 clk = ~clk;

    irq_status_ctrl #(.NUM_SRC(W)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .evt_i           (evt),
        .wr_en_i         (we),
        .wr_sel_i        (wsel),
        .wr_data_i       (wdata),
        .rd_sel_i        (rsel),
        .rd_data_o       (rd_data),
        .irq_drive_low_o (drive_low),
        .irq_n_o         (irq_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: one clock of stimulus plus its expected result
    task automatic step(input logic [W-1:0] e, input bit w, input bit ws,
                        input logic [W-1:0] d, input bit rs, input string tag);
        logic [W-1:0] clr, st_n, mk_n, a_old, a_new;
        bit           partial;
        exp_t         it;
        @(negedge clk);
        evt = e; we = w; wsel = ws; wdata = d; rsel = rs;
        clr     = (w && !ws) ? d : '0;
        a_old   = m_st & ~m_mk;
        st_n    = (m_st & ~clr) | e;
        mk_n    = (w && ws) ? d : m_mk;
        a_new   = st_n & ~mk_n;
        partial = ($countones(a_old) > 1) && ((a_old & clr & ~e) != '0) && (a_new != '0);
        m_st = st_n;
        m_mk = mk_n;
        it.irq_n = !((a_new != '0) && !partial);
        it.rd    = rs ? mk_n : st_n;
        it.rsel  = rs;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check(irq_n == it.irq_n, it.tag, "irq_n",
                      {{(W-1){1'b0}}, irq_n}, {{(W-1){1'b0}}, it.irq_n});
                check(rd_data == it.rd, it.tag, it.rsel ? "mask read" : "status read",
                      rd_data, it.rd);
                check(drive_low == !irq_n, "R10", "drive_low vs irq_n",
                      {{(W-1){1'b0}}, drive_low}, {{(W-1){1'b0}}, !irq_n});
            end
        end
    end

    initial begin
        m_st = '0;
        m_mk = '1;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(irq_n == 1'b1, "R9", "irq_n in reset", {{(W-1){1'b0}}, irq_n}, 1);
        check(rd_data == '0, "R9", "status in reset", rd_data, '0);
        rsel = 1'b1;
        #1;
        check(rd_data == '1, "R9", "mask in reset", rd_data, '1);
        rst_n = 1'b1;

        step('0, 1, 1, 16'hFFF0, 1, "R7");      // unmask bits 0..3
        step(16'h0001, 0, 0, '0, 0, "R1");      // unmasked event
        step('0, 0, 0, '0, 1, "R8");            // read mask, no side effect
        step('0, 0, 0, '0, 0, "R8");
        step('0, 1, 0, 16'h0001, 0, "R6");      // full ack of single source
        step(16'h0100, 0, 0, '0, 0, "R1");      // masked event, line stays high
        step('0, 1, 0, 16'h0000, 0, "R3");      // zero write keeps status
        step('0, 1, 1, 16'hFFF0, 0, "R3");      // mask write leaves status
        step(16'h0006, 0, 0, '0, 0, "R1");      // two sources pending
        step('0, 1, 0, 16'h0002, 0, "R5");      // partial ack: gap
        step('0, 0, 0, '0, 0, "R5");            // reassert
        step(16'h0004, 1, 0, 16'h0004, 0, "R4");// set beats clear
        step('0, 1, 0, 16'h0100, 0, "R2");      // clear masked bit only
        step(16'h0008, 0, 0, '0, 0, "R1");
        step(16'h0001, 1, 0, 16'h0008, 0, "R5");// race: new event with partial ack
        step('0, 0, 0, '0, 0, "R5");
        step('0, 1, 0, 16'h000D, 0, "R6");      // ack everything at once
        step(16'h0200, 0, 0, '0, 0, "R1");      // masked pending
        step('0, 1, 1, 16'hFDF0, 1, "R7");      // unmask pending bit
        step('0, 1, 0, 16'hFFFF, 0, "R2");      // clear all
        step('0, 0, 0, '0, 1, "R8");
        step('0, 0, 0, '0, 0, "R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule